// File: doc/BRIEF.md
# Boundary Scan Data Path

This block is the test data side of a boundary scan port. It sits between a group of device pins and the core logic. An external test access state machine drives it through single-cycle strobes: capture, shift and update of the data register, update of the instruction, and return to the test-logic-reset state. It receives the test clock, serial test input data and a parallel instruction word. It returns serial test output data, and it controls the multiplexers between pins and core.

Only the four most significant bits of the instruction word select the mode. Six modes are supported:

- **Pass-through with a one-bit bypass stage.**
- **Sample/preload.** This mode is observation only. It also loads the hold latches.
- **External test.** Pins are driven from the hold latches.
- **Identification readout.**
- **Clamp.** Pins come from the latches while the bypass stage is used.
- **All-outputs-off.**

Every boundary cell has two parts: a capture/shift flop, and a parallel hold latch that can drive the pin side. A board tester first preloads safe values with sample/preload, then switches to external test. During external test it reads back input pin states, and each shift pass both unloads the previous result and loads the next stimulus.

Top module: `bscan_top`

## Requirements
- R1: The mode comes from the upper four instruction bits, and the lower bits are ignored. The codes are: 1111 bypass, 0100 sample/preload, 0000 external test, 0101 identification, 0010 clamp, 0011 all-outputs-off. Every other code acts as bypass.
- R2: The active mode changes only on a rising test clock edge with `update_ir` high. `rst` or `tlr` sets it to identification.
- R3: In bypass, clamp and all-outputs-off, the scan path is a single stage. A capture loads it with 0, and each shift loads it from `tdi`.
- R4: In identification, a capture loads a 32-bit constant whose bit 0 is 1. The constant is shifted out least significant bit first.
- R5: In sample/preload and external test, a capture loads each cell with the value at its pin boundary. Input cells take `pin_in`. Output cells take the driven `pin_out` and `pin_oe`.
- R6: In the boundary modes, each shift moves every cell one place toward `tdo`, and `tdi` enters the last cell. Cell 0 is nearest `tdo`. Cells 0..NUM_IN-1 are inputs, the next NUM_OUT cells are output data, and the last NUM_OUT cells are output enables.
- R7: `update_dr` copies the shift cells into the hold latches only in sample/preload and external test. In every other mode it leaves the latches unchanged.
- R8: In bypass, sample/preload and identification, `pin_out`=`core_out`, `pin_oe`=`core_oe` and `core_in`=`pin_in`, even while capturing, shifting or updating.
- R9: In external test, `pin_out`, `pin_oe` and `core_in` come continuously from the hold latches. Over repeated passes, the shift that loads stimulus N unloads result N-1.
- R10: In clamp, `pin_out` and `pin_oe` come from the hold latches and `core_in` follows `pin_in`.
- R11: In all-outputs-off, every bit of `pin_oe` is 0.
- R12: `tdo` and `tdo_valid` change on the falling test clock edge. `tdo_valid` is high only if `shift_dr` was high at that edge. When `shift_dr` is low, `tdo` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tlr | input | 1 | Test-logic-reset state strobe |
| capture_dr | input | 1 | Capture data register strobe |
| shift_dr | input | 1 | Shift data register strobe |
| update_dr | input | 1 | Update data register strobe |
| update_ir | input | 1 | Instruction update strobe |
| ir_value | input | IR_W | Parallel instruction word |
| tdi | input | 1 | Serial test data in |
| pin_in | input | NUM_IN | Values arriving at input pins |
| core_in | output | NUM_IN | Input values delivered to the core |
| core_out | input | NUM_OUT | Output data from the core |
| core_oe | input | NUM_OUT | Output enables from the core |
| pin_out | output | NUM_OUT | Data driven to output pins |
| pin_oe | output | NUM_OUT | Enables driven to output pins |
| tdo | output | 1 | Serial test data out |
| tdo_valid | output | 1 | High while `tdo` carries shifted data |

## Verification
Some rules are checked on every cycle:

- All-outputs-off leaves no enable active.
- The mode holds without an instruction strobe.
- The hold latches stay fixed outside update in a boundary mode.
- A boundary shift moves the chain by exactly one place.
- The pass-through and external-test multiplexers follow the mode.
- `tdo` holds when no shift is active.

Only the bench scenarios can show the serial content: the identification constant, the captured pin images, the one-cycle bypass delay, the codes that fall back to bypass, and the overlap of result N-1 with stimulus N across two external-test passes.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    localparam int OP_W = 4;
    localparam int ID_W = 32;

    typedef enum logic [2:0] {
        M_BYPASS,
        M_SAMPLE,
        M_EXTEST,
        M_IDCODE,
        M_CLAMP,
        M_HIGHZ
    } scan_mode_e;

    localparam logic [OP_W-1:0] OP_EXTEST = 4'b0000;
    localparam logic [OP_W-1:0] OP_CLAMP  = 4'b0010;
    localparam logic [OP_W-1:0] OP_HIGHZ  = 4'b0011;
    localparam logic [OP_W-1:0] OP_SAMPLE = 4'b0100;
    localparam logic [OP_W-1:0] OP_IDCODE = 4'b0101;
    localparam logic [OP_W-1:0] OP_BYPASS = 4'b1111;

    // Control flags that a mode implies for the datapath
    typedef struct packed {
        logic boundary;        // chain is the selected data register
        logic pins_from_latch; // pin side driven by hold latches
        logic core_from_latch; // core inputs driven by hold latches
        logic force_off;       // all output enables forced low
        logic use_id;          // identification register selected
    } mode_ctl_t;

    function automatic scan_mode_e decode_op(logic [OP_W-1:0] op);
        scan_mode_e m;
        case (op)
            OP_EXTEST: m = M_EXTEST;
            OP_CLAMP:  m = M_CLAMP;
            OP_HIGHZ:  m = M_HIGHZ;
            OP_SAMPLE: m = M_SAMPLE;
            OP_IDCODE: m = M_IDCODE;
            default:   m = M_BYPASS;  // includes 1111 and all unknown codes
        endcase
        return m;
    endfunction

    function automatic mode_ctl_t mode_ctl(scan_mode_e m);
        mode_ctl_t c;
        c = '0;
        case (m)
            M_SAMPLE: c.boundary = 1'b1;
            M_EXTEST: begin
                c.boundary        = 1'b1;
                c.pins_from_latch = 1'b1;
                c.core_from_latch = 1'b1;
            end
            M_IDCODE: c.use_id = 1'b1;
            M_CLAMP:  c.pins_from_latch = 1'b1;
            M_HIGHZ:  c.force_off = 1'b1;
            default:  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bscan_ir_decode.sv
module bscan_ir_decode
    import bscan_pkg::*;
#(
    parameter int IR_W = 8
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            tlr,
    input  logic            update_ir,
    input  logic [IR_W-1:0] ir_value,
    output scan_mode_e      mode_q
);

    localparam int LOW_W = IR_W - OP_W;

    logic [OP_W-1:0] op;
    logic            unused_ir_low;

    assign op            = ir_value[IR_W-1 -: OP_W];
    assign unused_ir_low = ^ir_value[LOW_W-1:0];

    always_ff @(posedge tck) begin
        if (rst || tlr) begin
            mode_q <= M_IDCODE;
        end else if (update_ir) begin
            mode_q <= decode_op(op);
        end
    end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4,
    localparam int LEN    = NUM_IN + 2 * NUM_OUT
) (
    input  logic           tck,
    input  logic           rst,
    input  logic           enable,
    input  logic           capture_dr,
    input  logic           shift_dr,
    input  logic           update_dr,
    input  logic           tdi,
    input  logic [LEN-1:0] cap_vec,
    output logic [LEN-1:0] sh_q,
    output logic [LEN-1:0] lat_q
);

    // Capture/shift stage; index 0 sits next to the serial output
    always_ff @(posedge tck) begin
        if (rst) begin
            sh_q <= '0;
        end else if (enable && capture_dr) begin
            sh_q <= cap_vec;
        end else if (enable && shift_dr) begin
            sh_q <= {tdi, sh_q[LEN-1:1]};
        end
    end

    // Parallel hold latches
    always_ff @(posedge tck) begin
        if (rst) begin
            lat_q <= '0;
        end else if (enable && update_dr) begin
            lat_q <= sh_q;
        end
    end

endmodule

// File: rtl/bscan_pinmux.sv
module bscan_pinmux
    import bscan_pkg::*;
#(
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4,
    localparam int LEN    = NUM_IN + 2 * NUM_OUT,
    localparam int OUT_LO = NUM_IN,
    localparam int OE_LO  = NUM_IN + NUM_OUT
) (
    input  mode_ctl_t        ctl,
    input  logic [LEN-1:0]   lat_q,
    input  logic [NUM_IN-1:0]  pin_in,
    output logic [NUM_IN-1:0]  core_in,
    input  logic [NUM_OUT-1:0] core_out,
    input  logic [NUM_OUT-1:0] core_oe,
    output logic [NUM_OUT-1:0] pin_out,
    output logic [NUM_OUT-1:0] pin_oe
);

    for (genvar k = 0; k < NUM_IN; k++) begin : g_in
        assign core_in[k] = ctl.core_from_latch ? lat_q[k] : pin_in[k];
    end

    for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
        assign pin_out[j] = ctl.pins_from_latch ? lat_q[OUT_LO + j] : core_out[j];
        assign pin_oe[j]  = ctl.force_off       ? 1'b0 :
                            ctl.pins_from_latch ? lat_q[OE_LO + j] : core_oe[j];
    end

endmodule

// File: rtl/bscan_top.sv
module bscan_top
    import bscan_pkg::*;
#(
    parameter int          NUM_IN   = 4,
    parameter int          NUM_OUT  = 4,
    parameter int          IR_W     = 8,
    parameter logic [31:0] ID_VALUE = 32'h4B1D_0C2F
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               tlr,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               update_ir,
    input  logic [IR_W-1:0]    ir_value,
    input  logic               tdi,
    input  logic [NUM_IN-1:0]  pin_in,
    output logic [NUM_IN-1:0]  core_in,
    input  logic [NUM_OUT-1:0] core_out,
    input  logic [NUM_OUT-1:0] core_oe,
    output logic [NUM_OUT-1:0] pin_out,
    output logic [NUM_OUT-1:0] pin_oe,
    output logic               tdo,
    output logic               tdo_valid
);

    localparam int LEN = NUM_IN + 2 * NUM_OUT;

    scan_mode_e      mode_q;
    mode_ctl_t       ctl;
    logic [LEN-1:0]  cap_vec;
    logic [LEN-1:0]  sh_q;
    logic [LEN-1:0]  lat_q;
    logic [ID_W-1:0] id_q;
    logic            byp_q;
    logic            serial_bit;
    logic            one_bit_sel;

    assign ctl         = mode_ctl(mode_q);
    assign one_bit_sel = !ctl.boundary && !ctl.use_id;
    assign cap_vec     = {pin_oe, pin_out, pin_in};

    bscan_ir_decode #(.IR_W(IR_W)) u_dec (
        .tck       (tck),
        .rst       (rst),
        .tlr       (tlr),
        .update_ir (update_ir),
        .ir_value  (ir_value),
        .mode_q    (mode_q)
    );

    bscan_chain #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chain (
        .tck        (tck),
        .rst        (rst),
        .enable     (ctl.boundary),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .cap_vec    (cap_vec),
        .sh_q       (sh_q),
        .lat_q      (lat_q)
    );

    bscan_pinmux #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_mux (
        .ctl      (ctl),
        .lat_q    (lat_q),
        .pin_in   (pin_in),
        .core_in  (core_in),
        .core_out (core_out),
        .core_oe  (core_oe),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    // Single-stage bypass register
    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q <= 1'b0;
        end else if (one_bit_sel && capture_dr) begin
            byp_q <= 1'b0;
        end else if (one_bit_sel && shift_dr) begin
            byp_q <= tdi;
        end
    end

    // Identification register
    always_ff @(posedge tck) begin
        if (rst) begin
            id_q <= '0;
        end else if (ctl.use_id && capture_dr) begin
            id_q <= ID_VALUE;
        end else if (ctl.use_id && shift_dr) begin
            id_q <= {tdi, id_q[ID_W-1:1]};
        end
    end

    always_comb begin
        case (mode_q)
            M_SAMPLE, M_EXTEST: serial_bit = sh_q[0];
            M_IDCODE:           serial_bit = id_q[0];
            default:            serial_bit = byp_q;
        endcase
    end

    // Serial output retimed on the falling edge
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo       <= 1'b0;
            tdo_valid <= 1'b0;
        end else begin
            tdo_valid <= shift_dr;
            if (shift_dr) begin
                tdo <= serial_bit;
            end
        end
    end

endmodule

// File: rtl/bscan_top_chk.sv
module bscan_top_chk
    import bscan_pkg::*;
#(
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4,
    localparam int LEN    = NUM_IN + 2 * NUM_OUT
) (
    input logic               tck,
    input logic               rst,
    input logic               tlr,
    input logic               capture_dr,
    input logic               shift_dr,
    input logic               update_dr,
    input logic               update_ir,
    input logic               tdi,
    input logic               tdo,
    input logic [NUM_IN-1:0]  pin_in,
    input logic [NUM_IN-1:0]  core_in,
    input logic [NUM_OUT-1:0] core_out,
    input logic [NUM_OUT-1:0] core_oe,
    input logic [NUM_OUT-1:0] pin_out,
    input logic [NUM_OUT-1:0] pin_oe,
    input scan_mode_e         mode_q,
    input logic               boundary,
    input logic [LEN-1:0]     sh_q,
    input logic [LEN-1:0]     lat_q
);

    a_r11_highz_no_drive: assert property (@(posedge tck) disable iff (rst)
        (mode_q == M_HIGHZ) |-> (pin_oe == '0));

    a_r2_mode_stable: assert property (@(posedge tck) disable iff (rst)
        (!update_ir && !tlr) |=> $stable(mode_q));

    a_r7_latch_hold: assert property (@(posedge tck) disable iff (rst)
        !(update_dr && boundary) |=> $stable(lat_q));

    a_r6_shift_step: assert property (@(posedge tck) disable iff (rst)
        (shift_dr && boundary && !capture_dr) |=>
            (sh_q == {$past(tdi), $past(sh_q[LEN-1:1])}));

    a_r8_pass_through: assert property (@(posedge tck) disable iff (rst)
        (mode_q == M_BYPASS || mode_q == M_SAMPLE || mode_q == M_IDCODE) |->
            (pin_out == core_out && pin_oe == core_oe && core_in == pin_in));

    a_r9_extest_drive: assert property (@(posedge tck) disable iff (rst)
        (mode_q == M_EXTEST) |->
            (pin_out == lat_q[NUM_IN +: NUM_OUT] &&
             pin_oe  == lat_q[NUM_IN + NUM_OUT +: NUM_OUT] &&
             core_in == lat_q[0 +: NUM_IN]));

    a_r12_tdo_hold: assert property (@(negedge tck) disable iff (rst)
        !shift_dr |=> $stable(tdo));

endmodule

bind bscan_top bscan_top_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
    .tck        (tck),
    .rst        (rst),
    .tlr        (tlr),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .update_ir  (update_ir),
    .tdi        (tdi),
    .tdo        (tdo),
    .pin_in     (pin_in),
    .core_in    (core_in),
    .core_out   (core_out),
    .core_oe    (core_oe),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .mode_q     (mode_q),
    .boundary   (ctl.boundary),
    .sh_q       (sh_q),
    .lat_q      (lat_q)
);

// File: tb/bscan_top_test.sv
module bscan_top_test;

    localparam int          NI  = 4;
    localparam int          NO  = 4;
    localparam int          LEN = NI + 2 * NO;
    localparam logic [31:0] EXP_ID = 32'h4B1D_0C2F;

    logic          tck = 1'b0;
    logic          rst, tlr, capture_dr, shift_dr, update_dr, update_ir, tdi;
    logic [7:0]    ir_value;
    logic [NI-1:0] pin_in, core_in;
    logic [NO-1:0] core_out, core_oe, pin_out, pin_oe;
    logic          tdo, tdo_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic  v;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 tck = ~tck;

    bscan_top #(.NUM_IN(NI), .NUM_OUT(NO), .IR_W(8), .ID_VALUE(EXP_ID)) uut (
        .tck(tck), .rst(rst), .tlr(tlr), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .update_ir(update_ir),
        .ir_value(ir_value), .tdi(tdi), .pin_in(pin_in), .core_in(core_in),
        .core_out(core_out), .core_oe(core_oe), .pin_out(pin_out),
        .pin_oe(pin_oe), .tdo(tdo), .tdo_valid(tdo_valid)
    );

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: pops one expected bit per valid falling edge
    always @(negedge tck) begin
        #1;
        if (!rst && tdo_valid) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected tdo_valid", 64'(tdo_valid), 64'd0);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                check(it.tag, 64'(tdo), 64'(it.v));
            end
        end
    end

    task automatic step();
        @(posedge tck);
        #1;
    endtask

    task automatic load_ir(logic [7:0] v);
        ir_value  = v;
        update_ir = 1'b1;
        step();
        update_ir = 1'b0;
    endtask

    task automatic do_capture();
        capture_dr = 1'b1;
        step();
        capture_dr = 1'b0;
    endtask

    task automatic do_update();
        update_dr = 1'b1;
        step();
        update_dr = 1'b0;
    endtask

    // Driver: pushes expected serial bits, then shifts
    task automatic shift_seq(int n, logic [63:0] tin, logic [63:0] exp, string tag);
        for (int k = 0; k < n; k++) begin
            exp_t it;
            it.v   = exp[k];
            it.tag = tag;
            exp_q.push_back(it);
            shift_dr = 1'b1;
            tdi      = tin[k];
            step();
        end
        shift_dr = 1'b0;
        tdi      = 1'b0;
    endtask

    function automatic logic [63:0] byp_exp(logic [63:0] tin);
        return tin << 1;
    endfunction

    initial begin
        repeat (150000) @(posedge tck);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tlr = 1'b0; capture_dr = 1'b0; shift_dr = 1'b0;
        update_dr = 1'b0; update_ir = 1'b0; tdi = 1'b0; ir_value = 8'h00;
        pin_in = 4'hA; core_out = 4'h5; core_oe = 4'hC;
        repeat (3) step();
        rst = 1'b0;
        step();

        // Reset state: identification mode, pass-through pins
        check("R2 reset tdo_valid", 64'(tdo_valid), 64'd0);
        check("R8 reset pin_out", 64'(pin_out), 64'(core_out));
        check("R8 reset pin_oe", 64'(pin_oe), 64'(core_oe));
        do_capture();
        shift_seq(32, 64'h0, 64'(EXP_ID), "R4 id after reset");

        // Instruction word without strobe has no effect
        ir_value = 8'h0F;  // external test code, not yet latched
        repeat (3) step();
        check("R2 no strobe pin_out", 64'(pin_out), 64'h5);

        // Sample/preload with arbitrary low bits
        load_ir(8'h4E);
        check("R8 sample pin_oe", 64'(pin_oe), 64'hC);
        do_capture();
        shift_seq(LEN, 64'hF69, 64'hC5A, "R5 R6 sample capture");
        do_update();
        check("R8 sample pins after update", 64'(pin_out), 64'h5);
        check("R8 sample core_in", 64'(core_in), 64'hA);

        // External test, first pass
        load_ir(8'h0B);
        pin_in = 4'h3;
        step();
        check("R9 extest pin_out preload", 64'(pin_out), 64'h6);
        check("R9 extest pin_oe preload", 64'(pin_oe), 64'hF);
        check("R9 extest core_in", 64'(core_in), 64'h9);
        do_capture();
        shift_seq(LEN, 64'h3C1, 64'hF63, "R9 extest pass1");
        check("R9 extest hold during shift", 64'(pin_out), 64'h6);
        do_update();
        check("R9 extest pin_out upd", 64'(pin_out), 64'hC);
        check("R9 extest pin_oe upd", 64'(pin_oe), 64'h3);
        check("R9 extest core_in upd", 64'(core_in), 64'h1);

        // Second pass: result N-1 out while stimulus N goes in
        pin_in = 4'hE;
        do_capture();
        shift_seq(LEN, 64'h0A5, 64'h3CE, "R9 extest pass2");

        // Clamp: latches keep pins, bypass path, update ignored
        load_ir(8'h2C);
        check("R10 clamp pin_out", 64'(pin_out), 64'hC);
        check("R10 clamp pin_oe", 64'(pin_oe), 64'h3);
        check("R10 clamp core_in", 64'(core_in), 64'hE);
        do_capture();
        shift_seq(4, 64'hD, byp_exp(64'hD), "R3 clamp bypass");
        do_update();
        check("R7 clamp update ignored", 64'(pin_out), 64'hC);
        repeat (3) step();
        check("R12 tdo holds", 64'(tdo), 64'd1);
        check("R12 tdo_valid low", 64'(tdo_valid), 64'd0);

        // All outputs off
        load_ir(8'h31);
        check("R11 highz pin_oe", 64'(pin_oe), 64'h0);
        do_capture();
        shift_seq(6, 64'h2B, byp_exp(64'h2B), "R3 R11 highz bypass");

        // Bypass code with arbitrary low bits
        load_ir(8'hF6);
        check("R1 R8 bypass pin_out", 64'(pin_out), 64'h5);
        check("R1 R8 bypass core_in", 64'(core_in), 64'hE);
        do_capture();
        shift_seq(8, 64'hB4, byp_exp(64'hB4), "R3 bypass");
        do_update();
        check("R7 bypass update ignored", 64'(pin_out), 64'h5);

        // Unknown code behaves as bypass
        load_ir(8'h90);
        check("R1 unknown pin_oe", 64'(pin_oe), 64'hC);
        do_capture();
        shift_seq(5, 64'h13, byp_exp(64'h13), "R1 unknown as bypass");

        // Explicit identification code
        load_ir(8'h5F);
        do_capture();
        shift_seq(32, 64'hFFFF_FFFF, 64'(EXP_ID), "R1 R4 idcode");

        // Test-logic-reset returns to identification
        load_ir(8'h00);
        check("R9 extest again", 64'(pin_out), 64'hC);
        tlr = 1'b1;
        step();
        tlr = 1'b0;
        check("R2 tlr pass-through", 64'(pin_out), 64'h5);
        do_capture();
        shift_seq(32, 64'h0, 64'(EXP_ID), "R2 R4 id after tlr");

        step();
        check("R12 scoreboard drained", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule